// File: doc/BRIEF.md
# Retransmit-capable transmit FIFO with DMA hold-off

This block sits between a DMA engine that pushes outgoing frame data and a half-duplex Ethernet MAC that drains it. Each entry holds one 32-bit word plus a first-word and a last-word marker. The DMA write side is paced by a single space indication. The MAC read side pops words and sees the frame markers of the word at the head.

When the MAC reports a collision while a frame's collision window is still open, the read position jumps back to the first word of that frame, and the frame is sent again. The window spans the first 16 words (64 bytes) of a frame. While the window is open, the words already sent still count as occupied, so a rewind can never find them overwritten. Once the window has passed, their space is released, and a later retry request is refused.

A programmable threshold, counted in 4-byte entries, throttles the DMA. When free space drops below the threshold, only one further 64-byte burst is admitted. Writing resumes when free space climbs above the threshold again. A value of 37 entries (148 bytes) keeps a full FIFO from being refilled during a collision window. Frames longer than the 2048-byte store stream through, as long as the MAC keeps reading.

Top module: `retry_txfifo`

## Requirements
- R1: After reset, `dma_space_ok` is 1, `mac_valid` is 0, and `retry_refused` and `underflow` are 0.
- R2: Words leave on `mac_data` in the order they were accepted. Each word keeps its `mac_first` and `mac_last` markers. A pop while `mac_valid` is 0 moves nothing.
- R3: The store holds 512 entries of 4 bytes. A write is accepted only when `dma_wr_valid` and `dma_space_ok` are both 1. `dma_space_ok` is never 1 when fewer than 16 entries are free.
- R4: With the threshold at 0, `dma_space_ok` is 1 exactly when at least 16 entries are free.
- R5: A `mac_retry` while the window is open sets the read position back to the frame's first word in the next cycle. A pop in the same cycle is discarded.
- R6: The window opens when a first-marked word is popped. It closes after 16 words of the frame have been popped, or when a last-marked word is popped. A `mac_retry` while the window is closed leaves the read position alone and pulses `retry_refused` in the following cycle.
- R7: While the window is open, free space is counted from the frame's first word, not from the read position.
- R8: Once free entries fall below `cfg_hold_thresh`, at most 16 more writes are accepted until free entries exceed `cfg_hold_thresh`.
- R9: A `cfg_hold_thresh` of 0 disables the hold-off.
- R10: `underflow` becomes 1, and stays 1 until reset, when a pop meets an empty FIFO inside a frame (after a first-marked word and before a last-marked word). A pop on an empty FIFO between frames leaves it at 0.
- R11: A frame longer than 512 words passes through intact, including retries inside its window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_wr_valid | input | 1 | DMA offers a word |
| dma_wr_data | input | 32 | Word offered by the DMA |
| dma_wr_first | input | 1 | Offered word is the first of a frame |
| dma_wr_last | input | 1 | Offered word is the last of a frame |
| dma_space_ok | output | 1 | Write accepted this cycle if offered |
| mac_pop | input | 1 | MAC consumes the head word |
| mac_valid | output | 1 | Head word is present |
| mac_data | output | 32 | Head word |
| mac_first | output | 1 | Head word opens a frame |
| mac_last | output | 1 | Head word closes a frame |
| mac_retry | input | 1 | Collision: resend the current frame |
| retry_refused | output | 1 | Previous retry came after the window closed |
| underflow | output | 1 | Sticky: pop on empty inside a frame |
| cfg_hold_thresh | input | 10 | Hold-off threshold in free entries |

## Verification
A behavioural queue model runs beside the block and is compared every cycle under several input patterns. Steady streaming of short frames with rare retries checks ordering and marker handling. A run that fills with no reads, then drains, separates the 16-entry space rule from the hold-off. Writing at full rate against slow reads with the threshold at 37 exposes the burst count and the release point. Frames of 700 words with frequent retries show that rewinds never read overwritten data, and that late retries are refused. A final directed run starves the MAC, both between frames and inside a frame, to tell the two underflow cases apart.

// File: rtl/retry_txfifo_pkg.sv
package retry_txfifo_pkg;
   typedef struct packed {
      logic first;
      logic last;
   } mark_t;

   localparam int unsigned MARK_W = 2;
endpackage

// File: rtl/retry_txfifo_ram.sv
module retry_txfifo_ram #(
   parameter int unsigned W     = 34,
   parameter int unsigned DEPTH = 512,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/retry_txfifo_rdctl.sv
module retry_txfifo_rdctl #(
   parameter int unsigned PW     = 10,
   parameter int unsigned WINDOW = 16,
   localparam int unsigned CW    = $clog2(WINDOW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pop,
   input  logic          retry,
   input  logic [PW-1:0] wr_ptr,
   input  logic          head_first,
   input  logic          head_last,
   output logic [PW-1:0] rd_ptr,
   output logic [PW-1:0] fs_ptr,
   output logic          win_open,
   output logic          valid,
   output logic          retry_refused,
   output logic          underflow
);
   logic [CW-1:0] sent_q;
   logic [CW-1:0] sent_n;
   logic          in_frame_q;
   logic          do_rewind;
   logic          do_pop;
   logic          win_n;

   assign valid     = (rd_ptr != wr_ptr);
   assign do_rewind = retry & win_open;
   assign do_pop    = pop & valid & ~do_rewind;
   assign sent_n    = head_first ? CW'(1) : sent_q + CW'(1);
   assign win_n     = ~head_last & (head_first | win_open) & (sent_n != CW'(WINDOW));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr        <= '0;
         fs_ptr        <= '0;
         win_open      <= 1'b0;
         sent_q        <= '0;
         in_frame_q    <= 1'b0;
         retry_refused <= 1'b0;
         underflow     <= 1'b0;
      end else begin
         retry_refused <= retry & ~win_open;
         if (do_rewind) begin
            rd_ptr <= fs_ptr;
            sent_q <= '0;
         end else if (do_pop) begin
            rd_ptr   <= rd_ptr + PW'(1);
            win_open <= win_n;
            if (head_first | win_open) sent_q <= sent_n;
            if (head_first) begin
               fs_ptr     <= rd_ptr;
               in_frame_q <= 1'b1;
            end
            if (head_last) in_frame_q <= 1'b0;
         end else if (pop & ~valid & in_frame_q) begin
            underflow <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/retry_txfifo_throttle.sv
module retry_txfifo_throttle #(
   parameter int unsigned DEPTH     = 512,
   parameter int unsigned AVAIL_MIN = 16,
   parameter int unsigned BURST     = 16,
   parameter bit          HOLD_EN   = 1'b1,
   localparam int unsigned PW       = $clog2(DEPTH) + 1,
   localparam int unsigned BW       = $clog2(BURST + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] wr_ptr,
   input  logic [PW-1:0] base_ptr,
   input  logic          wr_req,
   input  logic [PW-1:0] thresh,
   output logic          space_ok,
   output logic          accept
);
   logic [PW-1:0] used;
   logic [PW-1:0] free_cnt;
   logic          room;

   assign used     = wr_ptr - base_ptr;
   assign free_cnt = PW'(DEPTH) - used;
   assign room     = (free_cnt >= PW'(AVAIL_MIN));
   assign accept   = wr_req & space_ok;

   if (HOLD_EN) begin : g_hold
      logic          hold_q;
      logic [BW-1:0] burst_q;
      logic          below;
      logic          above;
      logic          held;
      logic [BW-1:0] burst_eff;

      assign below     = (free_cnt < thresh);
      assign above     = (free_cnt > thresh);
      assign held      = hold_q | below;
      assign burst_eff = hold_q ? burst_q : BW'(BURST);
      assign space_ok  = room & (~held | (burst_eff != '0));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hold_q  <= 1'b0;
            burst_q <= '0;
         end else if (above) begin
            hold_q <= 1'b0;
         end else if (held) begin
            hold_q  <= 1'b1;
            burst_q <= burst_eff - (accept ? BW'(1) : BW'(0));
         end
      end
   end else begin : g_nohold
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, thresh};
      assign space_ok  = room;
   end
endmodule

// File: rtl/retry_txfifo.sv
module retry_txfifo
   import retry_txfifo_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DEPTH     = 512,
   parameter int unsigned AVAIL_MIN = 16,
   parameter int unsigned BURST     = 16,
   parameter int unsigned WINDOW    = 16,
   parameter bit          HOLD_EN   = 1'b1,
   localparam int unsigned AW       = $clog2(DEPTH),
   localparam int unsigned PW       = AW + 1,
   localparam int unsigned EW       = DATA_W + MARK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_wr_valid,
   input  logic [DATA_W-1:0] dma_wr_data,
   input  logic              dma_wr_first,
   input  logic              dma_wr_last,
   output logic              dma_space_ok,
   input  logic              mac_pop,
   output logic              mac_valid,
   output logic [DATA_W-1:0] mac_data,
   output logic              mac_first,
   output logic              mac_last,
   input  logic              mac_retry,
   output logic              retry_refused,
   output logic              underflow,
   input  logic [PW-1:0]     cfg_hold_thresh
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (AVAIL_MIN < 1 || AVAIL_MIN > DEPTH) begin : g_bad_avail
      $error("AVAIL_MIN must lie in 1..DEPTH");
   end
   if (WINDOW < 1 || WINDOW >= DEPTH) begin : g_bad_window
      $error("WINDOW must lie in 1..DEPTH-1");
   end
   if (BURST < 1) begin : g_bad_burst
      $error("BURST must be at least 1");
   end

   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] rd_ptr;
   logic [PW-1:0] fs_ptr;
   logic [PW-1:0] base_ptr;
   logic          win_open;
   logic          wr_accept;
   logic [EW-1:0] head;
   mark_t         wr_mark;
   mark_t         head_mark;

   assign wr_mark   = '{first: dma_wr_first, last: dma_wr_last};
   assign base_ptr  = win_open ? fs_ptr : rd_ptr;
   assign head_mark = mark_t'(head[EW-1 -: MARK_W]);
   assign mac_data  = head[DATA_W-1:0];
   assign mac_first = head_mark.first;
   assign mac_last  = head_mark.last;

   always_ff @(posedge clk) begin
      if (!rst_n)        wr_ptr <= '0;
      else if (wr_accept) wr_ptr <= wr_ptr + PW'(1);
   end

   retry_txfifo_ram #(.W(EW), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .we    (wr_accept),
      .waddr (wr_ptr[AW-1:0]),
      .wdata ({wr_mark, dma_wr_data}),
      .raddr (rd_ptr[AW-1:0]),
      .rdata (head)
   );

   retry_txfifo_throttle #(
      .DEPTH(DEPTH), .AVAIL_MIN(AVAIL_MIN), .BURST(BURST), .HOLD_EN(HOLD_EN)
   ) u_throttle (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ptr   (wr_ptr),
      .base_ptr (base_ptr),
      .wr_req   (dma_wr_valid),
      .thresh   (cfg_hold_thresh),
      .space_ok (dma_space_ok),
      .accept   (wr_accept)
   );

   retry_txfifo_rdctl #(.PW(PW), .WINDOW(WINDOW)) u_rdctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .pop           (mac_pop),
      .retry         (mac_retry),
      .wr_ptr        (wr_ptr),
      .head_first    (head_mark.first),
      .head_last     (head_mark.last),
      .rd_ptr        (rd_ptr),
      .fs_ptr        (fs_ptr),
      .win_open      (win_open),
      .valid         (mac_valid),
      .retry_refused (retry_refused),
      .underflow     (underflow)
   );
endmodule

// File: rtl/retry_txfifo_chk.sv
module retry_txfifo_chk #(
   parameter int unsigned DEPTH = 512,
   parameter int unsigned PW    = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          dma_wr_valid,
   input logic          dma_space_ok,
   input logic          mac_pop,
   input logic          mac_valid,
   input logic          mac_retry,
   input logic          retry_refused,
   input logic          underflow,
   input logic          win_open,
   input logic [PW-1:0] wr_ptr,
   input logic [PW-1:0] rd_ptr,
   input logic [PW-1:0] fs_ptr
);
   logic [PW-1:0] held_words;
   assign held_words = wr_ptr - (win_open ? fs_ptr : rd_ptr);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_wr_valid && dma_space_ok) |-> (held_words < PW'(DEPTH)));

   p_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mac_retry && win_open) |=> (rd_ptr == $past(fs_ptr)));

   p_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mac_retry && !win_open) |=> retry_refused);

   p_sticky_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);

   p_empty_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mac_pop && !mac_valid && !mac_retry) |=> $stable(rd_ptr));
endmodule

bind retry_txfifo retry_txfifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .dma_wr_valid  (dma_wr_valid),
   .dma_space_ok  (dma_space_ok),
   .mac_pop       (mac_pop),
   .mac_valid     (mac_valid),
   .mac_retry     (mac_retry),
   .retry_refused (retry_refused),
   .underflow     (underflow),
   .win_open      (win_open),
   .wr_ptr        (wr_ptr),
   .rd_ptr        (rd_ptr),
   .fs_ptr        (fs_ptr)
);

// File: tb/tb_retry_txfifo.sv
module tb_retry_txfifo;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 512;
   localparam int MINF = 16;
   localparam int BUR  = 16;
   localparam int WIN  = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dma_wr_valid = 1'b0;
   logic [31:0] dma_wr_data = '0;
   logic        dma_wr_first = 1'b0;
   logic        dma_wr_last = 1'b0;
   logic        dma_space_ok;
   logic        mac_pop = 1'b0;
   logic        mac_valid;
   logic [31:0] mac_data;
   logic        mac_first;
   logic        mac_last;
   logic        mac_retry = 1'b0;
   logic        retry_refused;
   logic        underflow;
   logic [9:0]  cfg_hold_thresh = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   retry_txfifo dut (.*);

   int errors = 0;
   int checks = 0;

   // reference model state
   int  m_dat [N];
   bit  m_fst [N];
   bit  m_lst [N];
   int  wr_n, rd_n, fs_n, cnt;
   bit  win, in_fr, hold, uf, refused;
   int  burst;
   // writer state
   int  f_len, f_pos, f_cnt, d_ctr;
   bit  long_mode;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int new_len();
      if (long_mode) return 700;
      return ((f_cnt * 37) % 40) + 1;
   endfunction

   function automatic int m_free();
      return N - (wr_n - (win ? fs_n : rd_n));
   endfunction

   function automatic bit m_space();
      int  fr = m_free();
      bit  held = hold || (fr < int'(cfg_hold_thresh));
      int  be = hold ? burst : BUR;
      return (fr >= MINF) && (!held || be > 0);
   endfunction

   task automatic model_reset();
      wr_n = 0; rd_n = 0; fs_n = 0; cnt = 0;
      win = 0; in_fr = 0; hold = 0; uf = 0; refused = 0; burst = 0;
      f_cnt = 0; f_pos = 0; d_ctr = 1; f_len = new_len();
   endtask

   task automatic compare();
      bit v = (rd_n != wr_n);
      chk("R3 R4 R7 R8 R9 space_ok", dma_space_ok, m_space());
      chk("R2 valid", mac_valid, v);
      if (v) begin
         chk("R2 R5 R11 data", mac_data, m_dat[rd_n % N]);
         chk("R2 first", mac_first, m_fst[rd_n % N]);
         chk("R2 last", mac_last, m_lst[rd_n % N]);
      end
      chk("R6 retry_refused", retry_refused, refused);
      chk("R10 underflow", underflow, uf);
   endtask

   // one cycle: called at a negedge, returns at the next negedge
   task automatic cycle(input bit wv, input bit pp, input bit rt);
      bit sp, acc, v;
      int fr, be, e;
      bit held;
      compare();
      dma_wr_valid = wv;
      dma_wr_data  = d_ctr;
      dma_wr_first = (f_pos == 0);
      dma_wr_last  = (f_pos == f_len - 1);
      mac_pop      = pp;
      mac_retry    = rt;
      fr   = m_free();
      held = hold || (fr < int'(cfg_hold_thresh));
      be   = hold ? burst : BUR;
      sp   = m_space();
      acc  = wv && sp;
      v    = (rd_n != wr_n);
      @(posedge clk);
      if (acc) begin
         m_dat[wr_n % N] = d_ctr;
         m_fst[wr_n % N] = (f_pos == 0);
         m_lst[wr_n % N] = (f_pos == f_len - 1);
         wr_n++; d_ctr++;
         if (f_pos == f_len - 1) begin f_cnt++; f_pos = 0; f_len = new_len(); end
         else f_pos++;
      end
      if (fr > int'(cfg_hold_thresh)) hold = 0;
      else if (held) begin hold = 1; burst = be - (acc ? 1 : 0); end
      refused = rt && !win;
      if (rt && win) begin
         rd_n = fs_n; cnt = 0;
      end else if (pp && v) begin
         e = rd_n % N;
         if (m_fst[e]) begin fs_n = rd_n; win = 1; cnt = 1; in_fr = 1; end
         else if (win) begin cnt++; if (cnt == WIN) win = 0; end
         if (m_lst[e]) begin win = 0; in_fr = 0; end
         rd_n++;
      end else if (pp && !v && in_fr) begin
         uf = 1;
      end
      @(negedge clk);
   endtask

   task automatic do_reset(input bit lm, input int thr);
      rst_n = 1'b0;
      dma_wr_valid = 0; mac_pop = 0; mac_retry = 0;
      cfg_hold_thresh = 10'(thr);
      long_mode = lm;
      repeat (3) @(posedge clk);
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run(input int n, input int pw, input int pp, input int pr);
      for (int i = 0; i < n; i++)
         cycle(($urandom % 100) < pw, ($urandom % 100) < pp, ($urandom % 1000) < pr);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed));
      // reset state
      do_reset(0, 0);
      chk("R1 space_ok", dma_space_ok, 1);
      chk("R1 valid", mac_valid, 0);
      chk("R1 refused", retry_refused, 0);
      chk("R1 underflow", underflow, 0);
      // streaming short frames, rare retries
      run(3000, 90, 70, 10);
      // fill without reads, threshold off, then drain
      do_reset(0, 0);
      run(600, 100, 0, 0);
      chk("R3 R9 full stop", dma_space_ok, 0);
      run(700, 0, 100, 0);
      // hold-off at 37 entries against slow reads
      do_reset(0, 37);
      run(3000, 100, 20, 0);
      // long frames with frequent retries
      do_reset(1, 37);
      run(4000, 100, 60, 30);
      do_reset(1, 0);
      run(3000, 95, 80, 40);
      // underflow: between frames, then inside a frame
      do_reset(0, 0);
      run(5, 0, 100, 0);
      chk("R10 no flag between frames", underflow, 0);
      long_mode = 1; f_len = 700;
      run(200, 30, 100, 0);
      chk("R10 flag inside frame", underflow, 1);
      compare();
      finish_run();
   end
endmodule